// File: doc/BRIEF.md
# Branchless Sequenced Register Processor

This block is a small 16-bit processor built around a sixteen-entry register file. It steps through a program that sits in an external instruction memory, fetching one 16-bit word per instruction over an 8-bit address bus. A second 8-bit address bus reads coefficient words from an external constant memory. Both memories are synchronous: a word appears on the data input one clock after its address was presented.

A host drives the block in three steps. While the processor is idle, it writes registers through a one-cycle load strobe. It then pulses `start`. Finally it waits for `done` and reads the results on the flat register view output. The instruction set has no branches. The only data-dependent behaviour is a select instruction, which picks one of two registers according to the sign of the most recent subtraction.

Instruction layout: opcode in bits [15:12], first source in [11:8], second source in [7:4], destination in [3:0]. The constant-load instruction uses [11:4] as its 8-bit constant address.

Top module: `tiny_seq_core`

## Requirements
- R1: After a synchronous active-low reset, `done` is 0, `fetch_addr` is 0, the sign flag is clear and every register reads 0.
- R2: When the processor is idle, a cycle with `host_we` high writes `host_data` into the register selected by `host_sel`. Register 0 always reads 0, and any write to it (host or instruction) is discarded.
- R3: A `host_we` cycle while a program is running leaves the selected register unchanged.
- R4: Opcode 0x3 writes first+second source and opcode 0x5 writes first−second source, both modulo 2^16.
- R5: Opcode 0x0 writes the first source shifted left by one with a 0 fill. Opcode 0x1 writes it shifted right by one with the sign bit copied (arithmetic).
- R6: Opcode 0x7 writes the constant-memory word at the address in bits [11:4] into the destination.
- R7: Opcode 0x6 writes the first source when the last subtraction result had bit 15 set, and the second source otherwise. Only opcode 0x5 updates that flag; add, shift, select and constant load leave it unchanged.
- R8: Opcode 0x8 raises `done` and stops fetching, so `fetch_addr` holds. A `start` pulse clears `done` and restarts execution at instruction address 0.
- R9: Each instruction advances `fetch_addr` by one. A program whose halt sits at address k, with c constant loads before it, raises `done` exactly 2k+2+c clocks after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins execution at address 0 |
| host_we | input | 1 | Host register write strobe (honoured only when idle) |
| host_sel | input | 4 | Register index for the host write |
| host_data | input | 16 | Data for the host write |
| instr_word | input | 16 | Instruction word returned one clock after `fetch_addr` |
| coef_word | input | 16 | Constant word returned one clock after `coef_addr` |
| done | output | 1 | High once a halt has executed, until the next start |
| fetch_addr | output | 8 | Instruction memory address (program counter) |
| coef_addr | output | 8 | Constant memory address |
| reg_view | output | 256 | All registers, register i in bits [16i+15:16i] |

## Verification
The arithmetic program uses operands at the positive limit (0x7FFF with 3). This separates wrapping add and subtract from saturating ones, and arithmetic right shift from logical. The select program places an add with a negative result and a shift between a subtraction and the select that follows it. A flag updated by any result would then pick the wrong register, while one updated only by subtraction picks the right one. The constant program reads from two separated addresses, which exposes a wrong address field. Counting cycles to `done` on every run pins the two-cycle instruction step and the extra cycle of a constant load. Host writes to register 0, and a host write injected mid-run, show up as unchanged register values at the ports.

// File: rtl/tsc_pkg.sv
// Package: shared opcode values and sequencer state type.
// Assumes a 4-bit opcode in the top nibble of each instruction.
package tsc_pkg;
    localparam logic [3:0] OP_SHL   = 4'h0;
    localparam logic [3:0] OP_SHR   = 4'h1;
    localparam logic [3:0] OP_ADD   = 4'h3;
    localparam logic [3:0] OP_SUB   = 4'h5;
    localparam logic [3:0] OP_SEL   = 4'h6;
    localparam logic [3:0] OP_CONST = 4'h7;
    localparam logic [3:0] OP_HALT  = 4'h8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_CONST = 2'd3
    } seq_state_e;
endpackage

// File: rtl/tsc_alu.sv
// Module: combinational datapath for one register-to-register instruction.
// Assumes: operands already read; flag is the sign of the last subtraction.
// Outputs the result and whether the opcode writes a destination at all.
module tsc_alu
    import tsc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         neg_flag,
    output logic [W-1:0] result,
    output logic         writes
);
    // Purpose: pick the operation selected by the opcode.
    always_comb begin
        result = '0;
        writes = 1'b1;
        case (op)
            OP_SHL:  result = {src_a[W-2:0], 1'b0};
            OP_SHR:  result = {src_a[W-1], src_a[W-1:1]};
            OP_ADD:  result = src_a + src_b;
            OP_SUB:  result = src_a - src_b;
            OP_SEL:  result = neg_flag ? src_a : src_b;
            default: writes = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsc_regfile.sv
// Module: register bank with one write port and two read ports.
// Assumes: index 0 is not stored and always reads zero; reset clears all.
module tsc_regfile #(
    parameter int W     = 16,
    parameter int NREGS = 16,
    localparam int SW   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SW-1:0]     waddr,
    input  logic [W-1:0]      wdata,
    input  logic [SW-1:0]     raddr_a,
    input  logic [SW-1:0]     raddr_b,
    output logic [W-1:0]      rdata_a,
    output logic [W-1:0]      rdata_b,
    output logic [NREGS*W-1:0] view
);
    logic [W-1:0] bank [1:NREGS-1];

    // Purpose: clear on reset, else store a write aimed at a nonzero index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < NREGS; i++) bank[i] <= '0;
        end else if (we && waddr != '0) begin
            bank[waddr] <= wdata;
        end
    end

    // Purpose: expose every register, index 0 as constant zero.
    for (genvar g = 0; g < NREGS; g++) begin : g_view
        if (g == 0) begin : g_zero
            assign view[W-1:0] = '0;
        end else begin : g_reg
            assign view[g*W +: W] = bank[g];
        end
    end

    assign rdata_a = view[raddr_a*W +: W];
    assign rdata_b = view[raddr_b*W +: W];
endmodule

// File: rtl/tsc_sequencer.sv
// Module: fetch/execute control with program counter and done flag.
// Assumes: instruction word arrives one clock after the counter is shown,
// and a constant word one clock after its address is shown.
module tsc_sequencer
    import tsc_pkg::*;
#(
    parameter int IAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [3:0]     op,
    output logic [IAW-1:0] pc,
    output logic           done,
    output logic           idle,
    output logic           exec_fire,
    output logic           const_fire
);
    seq_state_e state;

    // Purpose: advance the state machine and the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_WAIT;
                    pc    <= '0;
                    done  <= 1'b0;
                end
                ST_WAIT: state <= ST_EXEC;
                ST_EXEC: begin
                    if (op == OP_HALT) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (op == OP_CONST) begin
                        state <= ST_CONST;
                    end else begin
                        state <= ST_WAIT;
                        pc    <= pc + 1'b1;
                    end
                end
                default: begin
                    state <= ST_WAIT;
                    pc    <= pc + 1'b1;
                end
            endcase
        end
    end

    assign idle       = (state == ST_IDLE);
    assign exec_fire  = (state == ST_EXEC);
    assign const_fire = (state == ST_CONST);
endmodule

// File: rtl/tiny_seq_core.sv
// Module: top of the branchless processor; joins sequencer, ALU and bank.
// Assumes: external synchronous memories with one clock of read latency;
// host writes registers only while idle.
module tiny_seq_core
    import tsc_pkg::*;
#(
    parameter int W     = 16,
    parameter int NREGS = 16,
    parameter int IAW   = 8,
    parameter int CAW   = 8,
    localparam int SW   = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               host_we,
    input  logic [SW-1:0]      host_sel,
    input  logic [W-1:0]       host_data,
    input  logic [W-1:0]       instr_word,
    input  logic [W-1:0]       coef_word,
    output logic               done,
    output logic [IAW-1:0]     fetch_addr,
    output logic [CAW-1:0]     coef_addr,
    output logic [NREGS*W-1:0] reg_view
);
    logic [3:0]    op;
    logic [SW-1:0] f_a, f_b, f_d, dest_q;
    logic [W-1:0]  rd_a, rd_b, alu_res, wdata;
    logic          alu_wr, idle, exec_fire, const_fire, neg_flag, we;
    logic [SW-1:0] waddr;

    assign op        = instr_word[15:12];
    assign f_a       = instr_word[11:8];
    assign f_b       = instr_word[7:4];
    assign f_d       = instr_word[3:0];
    assign coef_addr = instr_word[11:4];

    tsc_sequencer #(.IAW(IAW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .pc(fetch_addr), .done(done), .idle(idle),
        .exec_fire(exec_fire), .const_fire(const_fire)
    );

    tsc_alu #(.W(W)) u_alu (
        .op(op), .src_a(rd_a), .src_b(rd_b), .neg_flag(neg_flag),
        .result(alu_res), .writes(alu_wr)
    );

    // Purpose: hold the destination of a constant load across its wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dest_q <= '0;
        else if (exec_fire && op == OP_CONST) dest_q <= f_d;
    end

    // Purpose: record the sign of each executed subtraction.
    always_ff @(posedge clk) begin
        if (!rst_n)                         neg_flag <= 1'b0;
        else if (exec_fire && op == OP_SUB) neg_flag <= alu_res[W-1];
    end

    // Purpose: choose the one register write source for this cycle.
    always_comb begin
        we    = 1'b0;
        waddr = f_d;
        wdata = alu_res;
        if (const_fire) begin
            we    = 1'b1;
            waddr = dest_q;
            wdata = coef_word;
        end else if (exec_fire) begin
            we    = alu_wr;
        end else if (idle && host_we) begin
            we    = 1'b1;
            waddr = host_sel;
            wdata = host_data;
        end
    end

    tsc_regfile #(.W(W), .NREGS(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr_a(f_a), .raddr_b(f_b), .rdata_a(rd_a), .rdata_b(rd_b),
        .view(reg_view)
    );
endmodule

// File: rtl/tsc_checker.sv
// Module: protocol checks on the processor, bound to the top module.
// Assumes: op is the opcode nibble of the current instruction input.
module tsc_checker
    import tsc_pkg::*;
#(
    parameter int IAW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done,
    input logic [IAW-1:0] fetch_addr,
    input logic [3:0]     op,
    input logic           neg_flag,
    input logic           exec_fire
);
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fetch_addr) |-> (fetch_addr == $past(fetch_addr) + 1'b1) || (fetch_addr == '0)); // R9
    AST_DONE_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(op) == OP_HALT && $past(exec_fire)); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !done); // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(fetch_addr)); // R8
    AST_FLAG_SUB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(neg_flag) |-> $past(exec_fire) && $past(op) == OP_SUB); // R7
endmodule

bind tiny_seq_core tsc_checker #(.IAW(IAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .fetch_addr(fetch_addr), .op(instr_word[15:12]),
    .neg_flag(neg_flag), .exec_fire(exec_fire)
);

// File: tb/tiny_seq_core_tb.sv
module tiny_seq_core_tb;
    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, host_we = 1'b0;
    logic [3:0]   host_sel = '0;
    logic [15:0]  host_data = '0, instr_word = '0, coef_word = '0;
    logic         done;
    logic [7:0]   fetch_addr, coef_addr;
    logic [255:0] reg_view;
    logic [15:0]  imem [256];
    logic [15:0]  cmem [256];
    int checks = 0, errors = 0, cycles = 0;

    always #2.5 clk = ~clk;

    tiny_seq_core u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .host_we(host_we),
        .host_sel(host_sel), .host_data(host_data), .instr_word(instr_word),
        .coef_word(coef_word), .done(done), .fetch_addr(fetch_addr),
        .coef_addr(coef_addr), .reg_view(reg_view)
    );

    // external memories: one clock read latency
    always @(posedge clk) begin
        instr_word <= imem[fetch_addr];
        coef_word  <= cmem[coef_addr];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] ins(input logic [3:0] o, a, b, d);
        return {o, a, b, d};
    endfunction

    function automatic logic [15:0] rg(input int i);
        return reg_view[i*16 +: 16];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) begin imem[i] = 16'h8000; cmem[i] = '0; end
    endtask

    task automatic host_load(input logic [3:0] sel, input logic [15:0] val);
        @(negedge clk); host_we = 1'b1; host_sel = sel; host_data = val;
        @(negedge clk); host_we = 1'b0;
    endtask

    // start, check restart state, count cycles to done, optionally inject a host write
    task automatic run(input string req, input int exp_cyc, input bit inject);
        int cyc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R8 done cleared by start", done, 0);
        chk("R8 restart at address 0", fetch_addr, 0);
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            host_we = inject && (cyc == 3);
            host_sel = 4'd14; host_data = 16'hDEAD;
        end
        host_we = 1'b0;
        chk({req, " R9 cycles to done"}, cyc, exp_cyc);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 done after reset", done, 0);
        chk("R1 fetch_addr after reset", fetch_addr, 0);
        for (int i = 0; i < 16; i++) chk("R1 register clear", rg(i), 0);
    endtask

    task automatic t_load();
        host_load(4'd1, 16'h1234);
        host_load(4'd5, 16'hBEEF);
        host_load(4'd0, 16'hFFFF);
        chk("R2 load r1", rg(1), 16'h1234);
        chk("R2 load r5", rg(5), 16'hBEEF);
        chk("R2 r0 stays zero", rg(0), 0);
    endtask

    task automatic t_arith();
        clear_prog();
        imem[0] = ins(4'h3, 4'd1, 4'd2, 4'd3);
        imem[1] = ins(4'h5, 4'd2, 4'd1, 4'd4);
        imem[2] = ins(4'h0, 4'd1, 4'd0, 4'd6);
        imem[3] = ins(4'h1, 4'd3, 4'd0, 4'd7);
        imem[4] = ins(4'h1, 4'd2, 4'd0, 4'd8);
        imem[5] = ins(4'h3, 4'd1, 4'd2, 4'd0);
        host_load(4'd1, 16'h7FFF);
        host_load(4'd2, 16'h0003);
        run("arith", 14, 0);
        chk("R4 add wraps", rg(3), 16'h8002);
        chk("R4 sub wraps", rg(4), 16'h8004);
        chk("R5 shift left zero fill", rg(6), 16'hFFFE);
        chk("R5 shift right keeps sign", rg(7), 16'hC001);
        chk("R5 shift right positive", rg(8), 16'h0001);
        chk("R2 instruction write to r0 discarded", rg(0), 0);
    endtask

    task automatic t_const();
        clear_prog();
        cmem[8'hAB] = 16'h1357;
        cmem[8'h10] = 16'h8000;
        imem[0] = {4'h7, 8'hAB, 4'd9};
        imem[1] = {4'h7, 8'h10, 4'd10};
        run("const", 8, 0);
        chk("R6 constant from 0xAB", rg(9), 16'h1357);
        chk("R6 constant from 0x10", rg(10), 16'h8000);
        chk("R8 halt holds fetch_addr", fetch_addr, 2);
        repeat (5) @(negedge clk);
        chk("R8 fetch_addr frozen after halt", fetch_addr, 2);
        chk("R8 done stays high", done, 1);
    endtask

    task automatic t_select();
        clear_prog();
        host_load(4'd1, 16'd5);
        host_load(4'd2, 16'd9);
        host_load(4'd3, 16'h0011);
        host_load(4'd4, 16'h0022);
        host_load(4'd11, 16'h8000);
        imem[0] = ins(4'h5, 4'd2, 4'd1, 4'd5);
        imem[1] = ins(4'h3, 4'd11, 4'd0, 4'd12);
        imem[2] = ins(4'h6, 4'd3, 4'd4, 4'd6);
        imem[3] = ins(4'h5, 4'd1, 4'd2, 4'd8);
        imem[4] = ins(4'h0, 4'd11, 4'd0, 4'd13);
        imem[5] = ins(4'h6, 4'd3, 4'd4, 4'd7);
        imem[6] = ins(4'h5, 4'd2, 4'd1, 4'd9);
        imem[7] = ins(4'h6, 4'd3, 4'd4, 4'd10);
        run("select", 18, 0);
        chk("R7 negative add leaves flag clear", rg(6), 16'h0022);
        chk("R7 negative sub picks first", rg(7), 16'h0011);
        chk("R7 positive sub picks second", rg(10), 16'h0022);
        chk("R4 sub negative result", rg(8), 16'hFFFC);
    endtask

    task automatic t_busy_load();
        clear_prog();
        host_load(4'd14, 16'h1111);
        for (int i = 0; i < 6; i++) imem[i] = ins(4'h3, 4'd0, 4'd0, 4'd15);
        run("busy", 14, 1);
        chk("R3 host write while running ignored", rg(14), 16'h1111);
    endtask

    initial begin
        clear_prog();
        t_reset();
        t_load();
        t_arith();
        t_const();
        t_select();
        t_busy_load();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule